// File: doc/BRIEF.md
# Serial ADC Host Controller

This block is the bus master for an 8-bit serial analog-to-digital converter that is reached over a chip select, a serial clock, a data-in line and a data-out line. A request comes in with a channel address. The block lowers chip select and derives the serial clock from the system clock through a divider. It sends optional zero padding, then a start bit of 1, then the channel address. Each of these bits changes only while the serial clock is low, so the converter always samples a settled bit on the rising edge.

The converter answers after one settling clock, whose bit is discarded. It then sends eight result bits, most significant first. When the converter also repeats the result least significant first, the block can collect the seven extra bits. It rebuilds the word and compares it with the first copy. Chip select then returns high, and the result appears with a one-cycle done pulse and a mismatch flag. A direction output tells board logic when the controller must stop driving a shared data wire.

Top module: `sadc_host`

## Requirements
- R1: During and after reset, with no request, cs_n is 1, sclk is 0, sdi_oe is 0, and busy and done are 0.
- R2: A request accepted at a clock edge drives cs_n low after that edge. sclk has a period of 2*HALF_DIV system clocks and starts low. Its first rising edge comes HALF_DIV clocks after cs_n falls. sclk is 0 whenever cs_n is 1.
- R3: On sdi the block sends LEAD_ZEROS zeros, then a single 1 (the start bit), then the ADDR_W address bits, most significant first. Each bit takes one serial-clock period, and sdi changes only in the cycle in which sclk falls or cs_n falls.
- R4: sdi_oe is 1 from the fall of cs_n through the end of the last address bit. It is 0 from the settling clock onward and whenever cs_n is 1.
- R5: The block ignores the bit of the settling clock that follows the address. It samples the next 8 bits of sdo on rising sclk edges, first bit as bit 7 of result.
- R6: With CHECK_REPEAT=1 the block clocks 7 more bits, which carry result bits 1 to 7 in that order. It rebuilds a word from them plus bit 0 of the first copy. mismatch is 1 exactly when that word differs from result. With CHECK_REPEAT=0 no extra clocks are sent and mismatch is 0.
- R7: In the cycle after the last falling sclk edge, cs_n is 1 and done is 1 for exactly one cycle. result and mismatch are updated in that same cycle and then hold their values until the next done.
- R8: busy is 1 from the cycle after acceptance until cs_n has stayed high for at least 2*HALF_DIV system clocks. The next transaction cannot start before then.
- R9: A request that arrives while busy is 1 is ignored. It neither changes the running transaction nor starts one later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Start a conversion (sampled while idle) |
| req_addr | input | ADDR_W | Channel address sent after the start bit |
| sdo | input | 1 | Converter data-out line |
| cs_n | output | 1 | Active-low chip select |
| sclk | output | 1 | Serial clock |
| sdi | output | 1 | Converter data-in line |
| sdi_oe | output | 1 | 1 while the controller drives the data-in wire |
| busy | output | 1 | A transaction or the closing gap is in progress |
| done | output | 1 | One-cycle pulse when result is valid |
| result | output | 8 | Converted value, bit 7 received first |
| mismatch | output | 1 | LSB-first repeat disagreed with result |

## Verification
Some properties are checked by assertions on every cycle:
- the serial clock stays low while chip select is high;
- sdi and its direction hold steady while the serial clock is high;
- done is a single pulse and coincides with chip select rising;
- chip select falls only after a request made while idle;
- every falling edge of chip select follows a high gap of at least one serial-clock period.

Other properties need the bench's converter model and scenarios:
- the order of the framed bits, including the padding count and the received address;
- discarding the settling bit;
- assembling the MSB-first result and detecting a corrupted repeat;
- that a request made while busy leaves no trace.

// File: rtl/sadc_pkg.sv
package sadc_pkg;
  localparam int RES_W = 8;
  localparam int REP_W = RES_W - 1;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_GAP  = 2'd2
  } sadc_state_e;
endpackage

// File: rtl/sadc_halfclk.sv
module sadc_halfclk #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick = run && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/sadc_framer.sv
module sadc_framer #(
  parameter int ADDR_W     = 3,
  parameter int LEAD_ZEROS = 1,
  parameter int SW         = 5
) (
  input  logic [SW-1:0]     slot,
  input  logic [ADDR_W-1:0] addr,
  output logic              bit_o,
  output logic              drive_o
);
  localparam int START_SLOT = LEAD_ZEROS;
  localparam int LAST_ADDR  = LEAD_ZEROS + ADDR_W;

  logic [ADDR_W-1:0] addr_sh;
  int                s;

  always_comb begin
    s       = int'(slot);
    addr_sh = addr << (s - START_SLOT - 1);
    bit_o   = 1'b0;
    drive_o = 1'b0;
    if (s < START_SLOT) begin
      drive_o = 1'b1;
    end else if (s == START_SLOT) begin
      bit_o   = 1'b1;
      drive_o = 1'b1;
    end else if (s <= LAST_ADDR) begin
      bit_o   = addr_sh[ADDR_W-1];
      drive_o = 1'b1;
    end
  end
endmodule

// File: rtl/sadc_capture.sv
module sadc_capture import sadc_pkg::*; #(
  parameter int MSB0         = 5,
  parameter int CHECK_REPEAT = 1,
  parameter int SW           = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             sample,
  input  logic [SW-1:0]    slot,
  input  logic             sdo,
  output logic [RES_W-1:0] word,
  output logic             differs
);
  localparam int LSB0 = MSB0 + RES_W;

  logic [RES_W-1:0] msb_q;
  int               s;

  assign s    = int'(slot);
  assign word = msb_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      msb_q <= '0;
    end else if (sample && s >= MSB0 && s < MSB0 + RES_W) begin
      msb_q <= {msb_q[RES_W-2:0], sdo};
    end
  end

  generate
    if (CHECK_REPEAT != 0) begin : g_repeat
      logic [REP_W-1:0] rep_q;
      always_ff @(posedge clk) begin
        if (rst || clear) begin
          rep_q <= '0;
        end else if (sample && s >= LSB0 && s < LSB0 + REP_W) begin
          rep_q <= {sdo, rep_q[REP_W-1:1]};
        end
      end
      assign differs = ({rep_q, msb_q[0]} != msb_q);
    end else begin : g_norepeat
      assign differs = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/sadc_host.sv
module sadc_host import sadc_pkg::*; #(
  parameter int HALF_DIV     = 4,
  parameter int ADDR_W       = 3,
  parameter int LEAD_ZEROS   = 1,
  parameter int CHECK_REPEAT = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              sdo,
  output logic              cs_n,
  output logic              sclk,
  output logic              sdi,
  output logic              sdi_oe,
  output logic              busy,
  output logic              done,
  output logic [RES_W-1:0]  result,
  output logic              mismatch
);
  localparam int MSB0  = LEAD_ZEROS + ADDR_W + 2;
  localparam int NSLOT = MSB0 + RES_W + ((CHECK_REPEAT != 0) ? REP_W : 0);
  localparam int SW    = $clog2(NSLOT + 1);

  sadc_state_e       state_q;
  logic [SW-1:0]     slot_q;
  logic [SW-1:0]     slot_nx;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] addr_sel;
  logic              gap_q;
  logic              sclk_q, cs_n_q, sdi_q, oe_q, done_q, mis_q;
  logic [RES_W-1:0]  res_q;
  logic              tick, fr_bit, fr_drv, start, last_slot, sample;
  logic [RES_W-1:0]  cap_word;
  logic              cap_diff;

  assign start     = (state_q == ST_IDLE) && req;
  assign last_slot = (slot_q == SW'(NSLOT - 1));
  assign slot_nx   = (state_q == ST_IDLE) ? '0 : slot_q + 1'b1;
  assign addr_sel  = (state_q == ST_IDLE) ? req_addr : addr_q;
  assign sample    = (state_q == ST_RUN) && tick && !sclk_q;

  sadc_halfclk #(.HALF_DIV(HALF_DIV)) u_div (
    .clk (clk),
    .rst (rst),
    .run (state_q != ST_IDLE),
    .tick(tick)
  );

  sadc_framer #(.ADDR_W(ADDR_W), .LEAD_ZEROS(LEAD_ZEROS), .SW(SW)) u_frame (
    .slot   (slot_nx),
    .addr   (addr_sel),
    .bit_o  (fr_bit),
    .drive_o(fr_drv)
  );

  sadc_capture #(.MSB0(MSB0), .CHECK_REPEAT(CHECK_REPEAT), .SW(SW)) u_cap (
    .clk    (clk),
    .rst    (rst),
    .clear  (start),
    .sample (sample),
    .slot   (slot_q),
    .sdo    (sdo),
    .word   (cap_word),
    .differs(cap_diff)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      slot_q  <= '0;
      addr_q  <= '0;
      gap_q   <= 1'b0;
      sclk_q  <= 1'b0;
      cs_n_q  <= 1'b1;
      sdi_q   <= 1'b0;
      oe_q    <= 1'b0;
      done_q  <= 1'b0;
      res_q   <= '0;
      mis_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (req) begin
            state_q <= ST_RUN;
            slot_q  <= '0;
            addr_q  <= req_addr;
            cs_n_q  <= 1'b0;
            sclk_q  <= 1'b0;
            sdi_q   <= fr_bit;
            oe_q    <= fr_drv;
          end
        end
        ST_RUN: begin
          if (tick) begin
            if (!sclk_q) begin
              sclk_q <= 1'b1;
            end else begin
              sclk_q <= 1'b0;
              if (last_slot) begin
                state_q <= ST_GAP;
                gap_q   <= 1'b0;
                cs_n_q  <= 1'b1;
                sdi_q   <= 1'b0;
                oe_q    <= 1'b0;
                done_q  <= 1'b1;
                res_q   <= cap_word;
                mis_q   <= cap_diff;
              end else begin
                slot_q <= slot_nx;
                sdi_q  <= fr_bit;
                oe_q   <= fr_drv;
              end
            end
          end
        end
        ST_GAP: begin
          if (tick) begin
            if (gap_q) state_q <= ST_IDLE;
            else       gap_q   <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cs_n     = cs_n_q;
  assign sclk     = sclk_q;
  assign sdi      = sdi_q;
  assign sdi_oe   = oe_q;
  assign busy     = (state_q != ST_IDLE);
  assign done     = done_q;
  assign result   = res_q;
  assign mismatch = mis_q;
endmodule

// File: rtl/sadc_host_chk.sv
module sadc_host_chk #(
  parameter int HALF_DIV = 4
) (
  input logic clk,
  input logic rst,
  input logic req,
  input logic busy,
  input logic cs_n,
  input logic sclk,
  input logic sdi,
  input logic sdi_oe,
  input logic done
);
  int hi_cnt;

  always_ff @(posedge clk) begin
    if (rst)                     hi_cnt <= 2 * HALF_DIV;
    else if (!cs_n)              hi_cnt <= 0;
    else if (hi_cnt < 2 * HALF_DIV) hi_cnt <= hi_cnt + 1;
  end

  // R2
  sclk_idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !sclk);

  // R3
  sdi_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (sclk && $past(sclk)) |-> ($stable(sdi) && $stable(sdi_oe)));

  // R4
  oe_idle_chk: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !sdi_oe);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7
  done_cs_rise_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> $rose(cs_n));

  // R8
  gap_len_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n) |-> (hi_cnt >= 2 * HALF_DIV));

  // R9
  start_req_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n) |-> $past(req && !busy));
endmodule

bind sadc_host sadc_host_chk #(.HALF_DIV(HALF_DIV)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .req   (req),
  .busy  (busy),
  .cs_n  (cs_n),
  .sclk  (sclk),
  .sdi   (sdi),
  .sdi_oe(sdi_oe),
  .done  (done)
);

// File: tb/sim_sadc_host.sv
module sim_sadc_host;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 3;
  localparam int AW   = 3;
  localparam int LEAD = 1;
  localparam int CHK  = 1;
  localparam int NS   = LEAD + AW + 2 + 8 + ((CHK != 0) ? 7 : 0);
  localparam int T    = NS * 2 * HALF;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic          sdo = 1'b0;
  logic          cs_n, sclk, sdi, sdi_oe, busy, done, mismatch;
  logic [7:0]    result;

  int n_chk = 0;
  int n_bad = 0;

  sadc_host #(.HALF_DIV(HALF), .ADDR_W(AW), .LEAD_ZEROS(LEAD), .CHECK_REPEAT(CHK)) u0 (
    .clk(clk), .rst(rst), .req(req), .req_addr(req_addr), .sdo(sdo),
    .cs_n(cs_n), .sclk(sclk), .sdi(sdi), .sdi_oe(sdi_oe), .busy(busy),
    .done(done), .result(result), .mismatch(mismatch)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // converter model
  logic [7:0]    conv_val = 8'h00;
  bit            corrupt  = 1'b0;
  logic [AW-1:0] rx_addr  = '0;
  int            ph = 0, ac = 0, oc = 0, lz = 0, oe_err = 0;
  logic          p_sclk = 1'b0, p_cs = 1'b1;

  always @(sclk, cs_n) begin
    if (cs_n === 1'b1) begin
      ph = 0;
      sdo = 1'b0;
    end else if (cs_n === 1'b0) begin
      if (p_cs) begin
        lz = 0; oe_err = 0; ph = 0;
      end
      if (sclk === 1'b1 && !p_sclk) begin
        if (ph == 0) begin
          if (!sdi_oe) oe_err++;
          if (sdi) begin ph = 1; ac = 0; end
          else lz++;
        end else if (ph == 1) begin
          if (!sdi_oe) oe_err++;
          rx_addr = {rx_addr[AW-2:0], sdi};
          ac++;
          if (ac == AW) begin ph = 2; oc = 0; end
        end else begin
          if (sdi_oe) oe_err++;
        end
      end else if (sclk === 1'b0 && p_sclk && ph == 2) begin
        if (oc == 0)       sdo = 1'b0;
        else if (oc <= 8)  sdo = conv_val[8-oc];
        else if (oc <= 15) sdo = conv_val[oc-8] ^ (corrupt && oc == 12);
        else               sdo = 1'b0;
        oc++;
      end
    end
    p_sclk = (sclk === 1'b1);
    p_cs   = (cs_n !== 1'b0);
  end

  // cycle model of timing
  bit mact = 1'b0;
  int mk   = 0;
  always @(posedge clk) begin
    if (rst) begin
      mact = 1'b0; mk = 0;
    end else if (mact) begin
      mk++;
      if (mk == T + 2 * HALF) mact = 1'b0;
    end else if (req) begin
      mact = 1'b1; mk = 0;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      logic [3:0] e_v, a_v;
      e_v = {!(mact && mk < T),
             (mact && mk < T && ((mk / HALF) % 2 == 1)),
             mact,
             (mact && mk == T)};
      a_v = {cs_n, sclk, busy, done};
      chk(a_v === e_v, "R2 R7 R8 R9 timing {cs_n,sclk,busy,done}", 32'(a_v), 32'(e_v));
    end
  end

  task automatic wait_done(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 4 * T; i++) begin
      @(negedge clk);
      if (done) begin seen = 1'b1; break; end
    end
  endtask

  task automatic txn(input logic [AW-1:0] a, input logic [7:0] v, input bit bad);
    bit seen;
    conv_val = v;
    corrupt  = bad;
    @(negedge clk);
    req = 1'b1; req_addr = a;
    @(negedge clk);
    req = 1'b0;
    wait_done(seen);
    chk(seen, "R7 done seen", 32'(seen), 1);
    chk(result === v, "R5 result", 32'(result), 32'(v));
    chk(mismatch === bad, "R6 mismatch", 32'(mismatch), 32'(bad));
    chk(rx_addr === a, "R3 address", 32'(rx_addr), 32'(a));
    chk(lz == LEAD, "R3 lead zeros", 32'(lz), 32'(LEAD));
    chk(oe_err == 0, "R4 direction", 32'(oe_err), 0);
    repeat (2 * HALF + 2) @(negedge clk);
    chk(result === v && mismatch === bad, "R7 result held", 32'({mismatch, result}), 32'({bad, v}));
  endtask

  initial begin
    bit seen;
    repeat (3) @(negedge clk);
    chk({cs_n, sclk, sdi_oe, busy, done} === 5'b10000, "R1 reset state",
        32'({cs_n, sclk, sdi_oe, busy, done}), 32'b10000);
    rst = 1'b0;
    @(negedge clk);
    chk({cs_n, sclk, sdi_oe, busy, done} === 5'b10000, "R1 idle state",
        32'({cs_n, sclk, sdi_oe, busy, done}), 32'b10000);

    txn(3'd0, 8'h00, 1'b0);
    txn(3'd7, 8'hFF, 1'b0);
    txn(3'd5, 8'hA5, 1'b0);
    txn(3'd2, 8'h5A, 1'b0);
    txn(3'd4, 8'h01, 1'b0);
    txn(3'd1, 8'h80, 1'b0);
    // R6 corrupted repeat
    txn(3'd6, 8'h3C, 1'b1);
    txn(3'd3, 8'hC3, 1'b0);

    // R9 request while busy
    conv_val = 8'h96; corrupt = 1'b0;
    @(negedge clk); req = 1'b1; req_addr = 3'd2;
    @(negedge clk); req = 1'b0;
    repeat (T / 2) @(negedge clk);
    req = 1'b1; req_addr = 3'd5;
    @(negedge clk); req = 1'b0;
    wait_done(seen);
    chk(result === 8'h96 && rx_addr === 3'd2, "R9 busy request ignored",
        32'({rx_addr, result}), 32'({3'd2, 8'h96}));
    repeat (2 * HALF + 6) @(negedge clk);
    chk(cs_n === 1'b1 && busy === 1'b0, "R9 no late start", 32'({cs_n, busy}), 32'b10);

    // R8 back-to-back with req held high
    conv_val = 8'h81;
    req = 1'b1; req_addr = 3'd1;
    wait_done(seen);
    chk(seen && result === 8'h81, "R8 first of pair", 32'(result), 32'h81);
    wait_done(seen);
    req = 1'b0;
    chk(seen && result === 8'h81, "R8 second of pair", 32'(result), 32'h81);
    repeat (2 * HALF + 4) @(negedge clk);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule